// File: doc/BRIEF.md
# Block-Compacting Memory

This block is an on-chip word memory with a built-in compaction engine. On a start strobe it drops the lowest block of words and slides every later word down by one block length toward address zero. The copy runs as a pipelined loop that moves one word per clock. Each word is read from its source address, which is the destination plus the block length. The word is then written to its destination. Because of this loop, the array needs only one read port and one write port.

User reads and writes keep running while a compaction is in progress and always take priority over the engine. In any cycle where the user holds the read port or the write port, the engine stalls and holds its position. At most one word is in flight inside the engine, and that word waits in a hold register until a free cycle comes. The highest block-length locations are never a destination, so they keep their contents. A `busy_o` level covers the whole operation, and a one-cycle `done_o` pulse marks its end.

Top module: `mem_block_mover`

## Requirements
- R1: The memory holds DEPTH words of WIDTH bits (defaults 1024 and 16). A write with `wr_en_i` high stores `wr_data_i` at the clock edge. A read with `rd_en_i` high presents the stored word on `rd_data_o` in the following cycle.
- R2: When a read and a write target the same address in the same cycle, `rd_data_o` returns the word stored before the write.
- R3: A start strobe taken while idle performs a compaction. Afterwards, the word at address a, for every a below DEPTH-BLK, equals the word that was at a+BLK before the start (BLK defaults to 60).
- R4: A compaction leaves the top BLK locations, from DEPTH-BLK to DEPTH-1, unchanged.
- R5: With no user access during the operation, `busy_o` rises in the cycle after the start strobe and stays high for exactly DEPTH-BLK+1 cycles. That is one cycle per word plus one pipeline cycle.
- R6: `done_o` is high for exactly one cycle, namely the cycle right after `busy_o` falls. `busy_o` and `done_o` are never high together.
- R7: Any cycle with `rd_en_i` or `wr_en_i` high stalls the engine. The final contents are identical to those of an uninterrupted compaction, with no word skipped or copied twice.
- R8: A start strobe that arrives while `busy_o` is high is ignored. The operation in progress is neither restarted nor extended in its result.
- R9: After reset, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | User read request |
| rd_addr_i | input | $clog2(DEPTH) | User read address |
| rd_data_o | output | WIDTH | Read data, valid the cycle after a user read |
| wr_en_i | input | 1 | User write request |
| wr_addr_i | input | $clog2(DEPTH) | User write address |
| wr_data_i | input | WIDTH | User write data |
| move_start_i | input | 1 | Start a compaction (ignored while busy) |
| busy_o | output | 1 | Compaction in progress |
| done_o | output | 1 | One-cycle pulse after the final copy |

## Verification
The first compaction runs over random contents with no user traffic at all. This isolates the engine's rate and its pipeline depth, and it yields the exact busy length. The second compaction runs with random user reads and same-value writes aimed at the top block, plus stray start strobes. The reads and writes create stalls at arbitrary pipeline phases, so its full readback shows a skipped or repeated word that a clean run would hide. The stray strobes show whether a restart would corrupt the already compacted low region. A directed read-write collision on one address shows the read-before-write order.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  localparam int unsigned MBM_DEPTH = 1024;
  localparam int unsigned MBM_WIDTH = 16;
  localparam int unsigned MBM_BLK   = 60;

  typedef enum logic {OWN_USER = 1'b0, OWN_MOVER = 1'b1} own_e;
endpackage

// File: rtl/mbm_array.sv
module mbm_array #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write on address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/mbm_port_arb.sv
module mbm_port_arb
  import mbm_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             u_re_i,
  input  logic [AW-1:0]    u_raddr_i,
  input  logic             u_we_i,
  input  logic [AW-1:0]    u_waddr_i,
  input  logic [WIDTH-1:0] u_wdata_i,
  input  logic             m_re_i,
  input  logic [AW-1:0]    m_raddr_i,
  input  logic             m_we_i,
  input  logic [AW-1:0]    m_waddr_i,
  input  logic [WIDTH-1:0] m_wdata_i,
  output logic             free_o,
  output logic             a_re_o,
  output logic [AW-1:0]    a_raddr_o,
  output logic             a_we_o,
  output logic [AW-1:0]    a_waddr_o,
  output logic [WIDTH-1:0] a_wdata_o
);
  own_e rd_own, wr_own;

  assign free_o = !u_re_i && !u_we_i;

  always_comb begin
    rd_own = u_re_i ? OWN_USER : OWN_MOVER;
    wr_own = u_we_i ? OWN_USER : OWN_MOVER;
    a_re_o    = (rd_own == OWN_USER) ? 1'b1      : m_re_i;
    a_raddr_o = (rd_own == OWN_USER) ? u_raddr_i : m_raddr_i;
    a_we_o    = (wr_own == OWN_USER) ? 1'b1      : m_we_i;
    a_waddr_o = (wr_own == OWN_USER) ? u_waddr_i : m_waddr_i;
    a_wdata_o = (wr_own == OWN_USER) ? u_wdata_i : m_wdata_i;
  end
endmodule

// File: rtl/mbm_move_seq.sv
module mbm_move_seq #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned BLK   = 60,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             free_i,
  input  logic [WIDTH-1:0] rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             re_o,
  output logic [AW-1:0]    raddr_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [WIDTH-1:0] wdata_o
);
  localparam logic [AW-1:0] BLK_A    = AW'(BLK);
  localparam logic [AW-1:0] LAST_SRC = AW'(DEPTH - 1);

  logic             busy_q, done_q, more_q, s1_q, hv_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [WIDTH-1:0] hd_q;
  logic             fin;

  // s1_q: word on array output; hv_q: word parked in hold reg
  assign re_o    = busy_q && more_q && free_i;
  assign raddr_o = src_q;
  assign we_o    = busy_q && (s1_q || hv_q) && free_i;
  assign waddr_o = dst_q;
  assign wdata_o = hv_q ? hd_q : rdata_i;
  assign fin     = we_o && !more_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      more_q <= 1'b0;
      s1_q   <= 1'b0;
      hv_q   <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      hd_q   <= '0;
    end else begin
      done_q <= fin;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          more_q <= 1'b1;
          src_q  <= BLK_A;
          s1_q   <= 1'b0;
          hv_q   <= 1'b0;
        end
      end else begin
        if (fin) busy_q <= 1'b0;
        s1_q <= re_o;
        if (re_o) begin
          dst_q  <= src_q - BLK_A;
          src_q  <= src_q + 1'b1;
          more_q <= (src_q != LAST_SRC);
        end
        if (we_o) hv_q <= 1'b0;
        else if (s1_q) begin
          hv_q <= 1'b1;
          hd_q <= rdata_i;
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q));
  // R6
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !free_i) |=> ($stable(src_q) && $stable(dst_q)));
  // R7
  single_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s1_q && hv_q));
  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && src_q != BLK_A) |=> (src_q != BLK_A));
endmodule

// File: rtl/mem_block_mover.sv
module mem_block_mover
  import mbm_pkg::*;
#(
  parameter int unsigned DEPTH = MBM_DEPTH,
  parameter int unsigned WIDTH = MBM_WIDTH,
  parameter int unsigned BLK   = MBM_BLK,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             move_start_i,
  output logic             busy_o,
  output logic             done_o
);
  logic             free;
  logic             m_re, m_we, a_re, a_we;
  logic [AW-1:0]    m_raddr, m_waddr, a_raddr, a_waddr;
  logic [WIDTH-1:0] m_wdata, a_wdata, a_rdata;

  mbm_port_arb #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_arb (
    .u_re_i(rd_en_i), .u_raddr_i(rd_addr_i),
    .u_we_i(wr_en_i), .u_waddr_i(wr_addr_i), .u_wdata_i(wr_data_i),
    .m_re_i(m_re), .m_raddr_i(m_raddr),
    .m_we_i(m_we), .m_waddr_i(m_waddr), .m_wdata_i(m_wdata),
    .free_o(free),
    .a_re_o(a_re), .a_raddr_o(a_raddr),
    .a_we_o(a_we), .a_waddr_o(a_waddr), .a_wdata_o(a_wdata)
  );

  mbm_move_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BLK(BLK)) u_seq (
    .clk_i, .rst_ni,
    .start_i(move_start_i), .free_i(free), .rdata_i(a_rdata),
    .busy_o, .done_o,
    .re_o(m_re), .raddr_o(m_raddr),
    .we_o(m_we), .waddr_o(m_waddr), .wdata_o(m_wdata)
  );

  mbm_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk_i, .rst_ni,
    .re_i(a_re), .raddr_i(a_raddr),
    .we_i(a_we), .waddr_i(a_waddr), .wdata_i(a_wdata),
    .rdata_o(a_rdata)
  );

  assign rd_data_o = a_rdata;

  // R7
  mover_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_we || m_re) |-> (!rd_en_i && !wr_en_i));
  // R4
  top_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_we |-> (m_waddr < AW'(DEPTH - BLK)));
endmodule

// File: tb/sim_mem_block_mover.sv
module sim_mem_block_mover;
  localparam int DEPTH = 1024;
  localparam int W     = 16;
  localparam int BLK   = 60;
  localparam int AW    = 10;
  localparam int NMOVE = DEPTH - BLK;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_en_i = 1'b0, wr_en_i = 1'b0, move_start_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0, wr_addr_i = '0;
  logic [W-1:0]  wr_data_i = '0;
  logic [W-1:0]  rd_data_o;
  logic          busy_o, done_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [W-1:0] ref_m [DEPTH];

  always #5 clk_i = ~clk_i;

  mem_block_mover u0 (
    .clk_i, .rst_ni, .rd_en_i, .rd_addr_i, .rd_data_o,
    .wr_en_i, .wr_addr_i, .wr_data_i, .move_start_i, .busy_o, .done_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int a, input logic [W-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    ref_m[a] = d;
  endtask

  task automatic rd_chk(input string req, input int a);
    rd_en_i = 1'b1; rd_addr_i = AW'(a);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    chk(req, 32'(rd_data_o), 32'(ref_m[a]));
  endtask

  task automatic check_all(input string lo_req, input string hi_req);
    for (int a = 0; a < DEPTH; a++) rd_chk((a < NMOVE) ? lo_req : hi_req, a);
  endtask

  function automatic void ref_move();
    for (int a = 0; a < NMOVE; a++) ref_m[a] = ref_m[a + BLK];
  endfunction

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic pend;
    logic [W-1:0] pexp;
    logic [W-1:0] old;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk_i);
    // R9 during reset
    chk("R9 busy in reset", 32'(busy_o), 0);
    chk("R9 done in reset", 32'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 busy after reset", 32'(busy_o), 0);
    chk("R9 done after reset", 32'(done_o), 0);

    // R1 fill and read back
    for (int a = 0; a < DEPTH; a++) wr_word(a, W'($urandom));
    check_all("R1", "R1");

    // R2 collision: read returns old word
    old = ref_m[77];
    rd_en_i = 1'b1; rd_addr_i = AW'(77);
    wr_en_i = 1'b1; wr_addr_i = AW'(77); wr_data_i = ~old;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    chk("R2 old word", 32'(rd_data_o), 32'(old));
    ref_m[77] = ~old;
    rd_chk("R2 new word", 77);

    // R5/R6 clean compaction
    move_start_i = 1'b1;
    @(negedge clk_i);
    move_start_i = 1'b0;
    chk("R5 busy rises", 32'(busy_o), 1);
    cnt = 0;
    while (busy_o && cnt < 5000) begin
      chk("R6 no overlap", 32'(done_o), 0);
      cnt++;
      @(negedge clk_i);
    end
    chk("R5 busy length", 32'(cnt), 32'(NMOVE + 1));
    chk("R6 done pulse", 32'(done_o), 1);
    @(negedge clk_i);
    chk("R6 done one cycle", 32'(done_o), 0);
    ref_move();
    check_all("R3", "R4");

    // R7/R8 compaction under random user traffic and stray starts
    move_start_i = 1'b1;
    @(negedge clk_i);
    move_start_i = 1'b0;
    pend = 1'b0; pexp = '0; cnt = 0;
    while (busy_o && cnt < 20000) begin
      if (pend) chk("R7 read during move", 32'(rd_data_o), 32'(pexp));
      pend = 1'b0;
      rd_en_i = 1'b0; wr_en_i = 1'b0; move_start_i = 1'b0;
      case ($urandom % 8)
        0, 1, 2: begin
          rd_en_i = 1'b1;
          rd_addr_i = AW'(NMOVE + int'($urandom % BLK));
          pexp = ref_m[rd_addr_i];
          pend = 1'b1;
        end
        3, 4: begin
          wr_en_i = 1'b1;
          wr_addr_i = AW'(NMOVE + int'($urandom % BLK));
          wr_data_i = ref_m[wr_addr_i];
        end
        5: move_start_i = 1'b1; // R8 stray start
        default: ;
      endcase
      cnt++;
      @(negedge clk_i);
    end
    rd_en_i = 1'b0; wr_en_i = 1'b0; move_start_i = 1'b0;
    if (pend) chk("R7 read during move", 32'(rd_data_o), 32'(pexp));
    chk("R7 stalls lengthen busy", 32'(cnt > NMOVE + 1), 1);
    chk("R6 done after stalled move", 32'(done_o), 1);
    @(negedge clk_i);
    ref_move();
    check_all("R7/R8", "R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule